// File: doc/BRIEF.md
# Processor Status Word Register

This block holds a 64-bit status-and-control word for a processor core. Four kinds of update reach it: a whole-word load from a value popped off the stack, a byte store that copies five arithmetic status flags from an 8-bit source, an arithmetic-unit update that changes only the flags chosen by a per-operation mask, and commands that set or clear the direction flag. When more than one request arrives in the same cycle, a fixed priority chooses which one takes effect.

Whatever path writes the word, the fixed bits are forced: one bit always reads 1, and the unused low bits and the whole upper field always read 0. The block drives the full word, for use by a push, and a byte view of its low eight bits. It also brings out the main flags as separate signals so that nearby logic can decode them without slicing the word.

Top module: `status_word_reg`

## Requirements
- R1: After synchronous active-low reset the word `flags_q` is 0x0000_0000_0000_0002.
- R2: In every cycle bit 1 of `flags_q` is 1, and bits 3, 5, 15 and 63:22 are 0, whichever update path wrote the word.
- R3: A full load (`pop_load_en`) sets the word to `pop_data`, except that bit 1 is forced to 1 and bits 3, 5, 15 and 63:22 are forced to 0. The result shows one cycle after the load.
- R4: `byte_out` always equals bits 7:0 of `flags_q`.
- R5: A byte store (`byte_store_en`) copies `byte_in` bits 0, 2, 4, 6 and 7 into the same bit positions of the word, where they are carry (0), parity (2), auxiliary carry (4), zero (6) and sign (7). Bits 1, 3 and 5 of `byte_in` have no effect, and every other bit of the word keeps its value.
- R6: An arithmetic update (`alu_upd_en`) uses `alu_flags` and `alu_mask` with index 0 = carry (bit 0), 1 = parity (bit 2), 2 = auxiliary (bit 4), 3 = zero (bit 6), 4 = sign (bit 7) and 5 = overflow (bit 11). Only word bits whose mask index is 1 take the matching flag value. All other bits keep their value, so an all-zero mask leaves the word unchanged.
- R7: `dir_set` makes bit 10 equal to 1 and `dir_clear` makes it 0, and no other bit changes. If both are asserted in the same cycle, the clear wins.
- R8: When requests coincide, the full load wins over the byte store, the byte store wins over the arithmetic update, and the arithmetic update wins over a direction command. Each losing request is dropped.
- R9: The flag outputs follow word bits: `carry_o` bit 0, `parity_o` bit 2, `aux_o` bit 4, `zero_o` bit 6, `sign_o` bit 7, `trap_o` bit 8 (single-step), `int_en_o` bit 9, `dir_o` bit 10, `ovf_o` bit 11.
- R10: In a cycle with no request the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pop_load_en | input | 1 | Load the whole word from `pop_data` |
| pop_data | input | 64 | Popped value |
| byte_store_en | input | 1 | Copy the five low status flags from `byte_in` |
| byte_in | input | 8 | Byte-store source |
| alu_upd_en | input | 1 | Apply a masked arithmetic flag update |
| alu_flags | input | 6 | Arithmetic flag values, index order as in R6 |
| alu_mask | input | 6 | Per-flag write enables, index order as in R6 |
| dir_clear | input | 1 | Clear the direction flag |
| dir_set | input | 1 | Set the direction flag |
| flags_q | output | 64 | Architecturally visible word |
| byte_out | output | 8 | Low byte of the word |
| carry_o | output | 1 | Carry flag |
| parity_o | output | 1 | Parity flag |
| aux_o | output | 1 | Auxiliary carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| trap_o | output | 1 | Single-step enable |
| int_en_o | output | 1 | Interrupt enable flag |
| dir_o | output | 1 | Direction flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The hardest case to reach from the ports is one where the losing update in a priority conflict would leave a visible mark. If the word already holds the value the loser would write, a dropped request looks the same as an applied one. So the stimulus first loads a word whose bits disagree with each competing request, then raises several enables in one cycle. Reserved-bit forcing is driven with all-ones and alternating patterns through both the full load and the byte store, so that every fixed bit meets an input that tries to flip it.

// File: rtl/sw_pkg.sv
// Package: shared widths, bit positions and masks of the status word.
// Assumes a 64-bit word whose defined flags sit in bits 21:0.
package sw_pkg;
    localparam int WORD_W = 64;
    localparam int BYTE_W = 8;
    localparam int N_ALU  = 6;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    // Bit 1 reads as one.
    localparam logic [WORD_W-1:0] FIXED_ONE  = WORD_W'(64'h2);
    // Defined bits: 0,2,4,6..14,16..21.
    localparam logic [WORD_W-1:0] WRITABLE   = WORD_W'(64'h3F_7FD5);
    // Flags moved by the byte store: 0,2,4,6,7.
    localparam logic [WORD_W-1:0] BYTE_FLAGS = WORD_W'(64'hD5);
    localparam logic [WORD_W-1:0] DIR_BIT    = WORD_W'(1) << POS_DF;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_POP,
        SRC_BYTE,
        SRC_ALU,
        SRC_DIR
    } upd_src_e;

    // Word bit position of arithmetic flag index i.
    function automatic int alu_pos(input int i);
        case (i)
            0:       return POS_CF;
            1:       return POS_PF;
            2:       return POS_AF;
            3:       return POS_ZF;
            4:       return POS_SF;
            default: return POS_OF;
        endcase
    endfunction
endpackage

// File: rtl/sw_alu_merge.sv
// Merges masked arithmetic flag results into the current word.
// Assumes flag index order carry, parity, aux, zero, sign, overflow.
module sw_alu_merge
    import sw_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [N_ALU-1:0]  flg,
    input  logic [N_ALU-1:0]  msk,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] sel_v;
    logic [WORD_W-1:0] val_v;

    // Scatter the flag index vectors to word positions and merge.
    always_comb begin
        sel_v = '0;
        val_v = '0;
        for (int i = 0; i < N_ALU; i++) begin
            sel_v[alu_pos(i)] = msk[i];
            val_v[alu_pos(i)] = flg[i];
        end
        merged = (cur & ~sel_v) | (val_v & sel_v);
    end
endmodule

// File: rtl/sw_update_sel.sv
// Picks the single update source for this cycle by fixed priority.
// Assumes request enables are already synchronous to the clock.
module sw_update_sel
    import sw_pkg::*;
(
    input  logic     pop_req,
    input  logic     byte_req,
    input  logic     alu_req,
    input  logic     dir_req,
    output upd_src_e src
);
    // Priority: pop, byte store, arithmetic, direction.
    always_comb begin
        if (pop_req)       src = SRC_POP;
        else if (byte_req) src = SRC_BYTE;
        else if (alu_req)  src = SRC_ALU;
        else if (dir_req)  src = SRC_DIR;
        else               src = SRC_HOLD;
    end
endmodule

// File: rtl/sw_fixup.sv
// Forces reserved bits of a candidate word to their fixed values.
// Assumes FIXED_ONE lies outside WRITABLE.
module sw_fixup
    import sw_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] fixed_w
);
    // Keep defined bits, then set the always-one bit.
    always_comb fixed_w = (raw & WRITABLE) | FIXED_ONE;
endmodule

// File: rtl/status_word_reg.sv
// Top: 64-bit status/control word with four prioritised update paths.
// Assumes one request of each kind at most per cycle; all paths pass
// through reserved-bit forcing before the register.
module status_word_reg
    import sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_load_en,
    input  logic [WORD_W-1:0] pop_data,
    input  logic              byte_store_en,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              alu_upd_en,
    input  logic [N_ALU-1:0]  alu_flags,
    input  logic [N_ALU-1:0]  alu_mask,
    input  logic              dir_clear,
    input  logic              dir_set,
    output logic [WORD_W-1:0] flags_q,
    output logic [BYTE_W-1:0] byte_out,
    output logic              carry_o,
    output logic              parity_o,
    output logic              aux_o,
    output logic              zero_o,
    output logic              sign_o,
    output logic              trap_o,
    output logic              int_en_o,
    output logic              dir_o,
    output logic              ovf_o
);
    upd_src_e          src;
    logic [WORD_W-1:0] alu_word;
    logic [WORD_W-1:0] raw_next;
    logic [WORD_W-1:0] fixed_next;
    logic [WORD_W-1:0] byte_word;

    sw_update_sel u_sel (
        .pop_req  (pop_load_en),
        .byte_req (byte_store_en),
        .alu_req  (alu_upd_en),
        .dir_req  (dir_clear | dir_set),
        .src      (src)
    );

    sw_alu_merge u_alu (
        .cur    (flags_q),
        .flg    (alu_flags),
        .msk    (alu_mask),
        .merged (alu_word)
    );

    // Widen the byte-store source to word width.
    always_comb byte_word = {{(WORD_W-BYTE_W){1'b0}}, byte_in};

    // Candidate next word for the chosen source.
    always_comb begin
        case (src)
            SRC_POP:  raw_next = pop_data;
            SRC_BYTE: raw_next = (flags_q & ~BYTE_FLAGS) | (byte_word & BYTE_FLAGS);
            SRC_ALU:  raw_next = alu_word;
            SRC_DIR:  raw_next = dir_clear ? (flags_q & ~DIR_BIT) : (flags_q | DIR_BIT);
            default:  raw_next = flags_q;
        endcase
    end

    sw_fixup u_fix (
        .raw     (raw_next),
        .fixed_w (fixed_next)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               flags_q <= FIXED_ONE;
        else if (src != SRC_HOLD) flags_q <= fixed_next;
    end

    // Byte view and individual flag outputs.
    always_comb begin
        byte_out = flags_q[BYTE_W-1:0];
        carry_o  = flags_q[POS_CF];
        parity_o = flags_q[POS_PF];
        aux_o    = flags_q[POS_AF];
        zero_o   = flags_q[POS_ZF];
        sign_o   = flags_q[POS_SF];
        trap_o   = flags_q[POS_TF];
        int_en_o = flags_q[POS_IF];
        dir_o    = flags_q[POS_DF];
        ovf_o    = flags_q[POS_OF];
    end
endmodule

// File: rtl/sw_checker.sv
// Checker: temporal properties of the status word, bound to the top.
// Assumes it observes the top's ports only.
module sw_checker
    import sw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pop_load_en,
    input logic [WORD_W-1:0] pop_data,
    input logic              byte_store_en,
    input logic [BYTE_W-1:0] byte_in,
    input logic              alu_upd_en,
    input logic [N_ALU-1:0]  alu_mask,
    input logic              dir_clear,
    input logic              dir_set,
    input logic [WORD_W-1:0] flags_q,
    input logic [BYTE_W-1:0] byte_out
);
    logic any_req;
    logic dir_only;
    logic alu_only;
    logic [WORD_W-1:0] alu_sel;

    // Request decode for the properties below.
    always_comb begin
        any_req  = pop_load_en | byte_store_en | alu_upd_en | dir_clear | dir_set;
        dir_only = (dir_clear | dir_set) & !pop_load_en & !byte_store_en & !alu_upd_en;
        alu_only = alu_upd_en & !pop_load_en & !byte_store_en;
        alu_sel  = '0;
        for (int i = 0; i < N_ALU; i++) alu_sel[alu_pos(i)] = alu_mask[i];
    end

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> (flags_q & ~WRITABLE) == FIXED_ONE); // R2
    AST_POP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pop_load_en |=> flags_q == (($past(pop_data) & WRITABLE) | FIXED_ONE)); // R3
    AST_BYTE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_out == flags_q[BYTE_W-1:0]); // R4
    AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_store_en && !pop_load_en |=> (flags_q & ~BYTE_FLAGS) == ($past(flags_q) & ~BYTE_FLAGS)); // R5
    AST_ALU_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        alu_only |=> (flags_q & ~$past(alu_sel)) == ($past(flags_q) & ~$past(alu_sel))); // R6
    AST_DIR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_only |=> flags_q[POS_DF] == !$past(dir_clear)); // R7
    AST_DIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        dir_only |=> (flags_q & ~DIR_BIT) == ($past(flags_q) & ~DIR_BIT)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> $stable(flags_q)); // R10
endmodule

bind status_word_reg sw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pop_load_en   (pop_load_en),
    .pop_data      (pop_data),
    .byte_store_en (byte_store_en),
    .byte_in       (byte_in),
    .alu_upd_en    (alu_upd_en),
    .alu_mask      (alu_mask),
    .dir_clear     (dir_clear),
    .dir_set       (dir_set),
    .flags_q       (flags_q),
    .byte_out      (byte_out)
);

// File: tb/sim_status_word_reg.sv
module sim_status_word_reg;
    import sw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pop_load_en, byte_store_en, alu_upd_en, dir_clear, dir_set;
    logic [63:0] pop_data;
    logic [7:0]  byte_in;
    logic [5:0]  alu_flags, alu_mask;
    logic [63:0] flags_q;
    logic [7:0]  byte_out;
    logic carry_o, parity_o, aux_o, zero_o, sign_o, trap_o, int_en_o, dir_o, ovf_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    status_word_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .pop_load_en(pop_load_en), .pop_data(pop_data),
        .byte_store_en(byte_store_en), .byte_in(byte_in),
        .alu_upd_en(alu_upd_en), .alu_flags(alu_flags), .alu_mask(alu_mask),
        .dir_clear(dir_clear), .dir_set(dir_set),
        .flags_q(flags_q), .byte_out(byte_out),
        .carry_o(carry_o), .parity_o(parity_o), .aux_o(aux_o), .zero_o(zero_o),
        .sign_o(sign_o), .trap_o(trap_o), .int_en_o(int_en_o), .dir_o(dir_o),
        .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        pop_load_en = 0; byte_store_en = 0; alu_upd_en = 0;
        dir_clear = 0; dir_set = 0;
        pop_data = '0; byte_in = '0; alu_flags = '0; alu_mask = '0;
    endtask

    // Inputs were set after a falling edge; one rising edge updates the word.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_pop(input logic [63:0] v);
        pop_load_en = 1; pop_data = v;
        step();
    endtask

    task automatic t_reset();
        chk("R1 reset word", flags_q, 64'h2);
        chk("R4 reset byte", {56'h0, byte_out}, 64'h2);
        chk("R9 reset flags", {55'h0, carry_o, parity_o, aux_o, zero_o, sign_o,
                               trap_o, int_en_o, dir_o, ovf_o}, 64'h0);
    endtask

    task automatic t_pop();
        do_pop('1);
        chk("R3 pop all ones", flags_q, 64'h3F_7FD7);
        chk("R2 reserved after ones", flags_q & ~64'h3F_7FD5, 64'h2);
        chk("R4 byte view", {56'h0, byte_out}, 64'hD7);
        chk("R9 trap int dir ovf", {60'h0, trap_o, int_en_o, dir_o, ovf_o}, 64'hF);
        do_pop(64'hAAAA_AAAA_AAAA_AAAA);
        chk("R3 pop alternating", flags_q, 64'h2A_2A82);
        chk("R9 sign zero", {62'h0, sign_o, zero_o}, 64'h2);
        do_pop('0);
        chk("R3 pop zero", flags_q, 64'h2);
    endtask

    task automatic t_byte();
        byte_store_en = 1; byte_in = 8'hFF;
        step();
        chk("R5 byte store ones", flags_q, 64'hD7);
        chk("R9 low flags", {59'h0, carry_o, parity_o, aux_o, zero_o, sign_o}, 64'h1F);
        do_pop('1);
        byte_store_en = 1; byte_in = 8'h00;
        step();
        chk("R5 byte store keeps upper", flags_q, 64'h3F_7F02);
        byte_store_en = 1; byte_in = 8'h2A;
        step();
        chk("R5 fixed byte bits ignored", flags_q, 64'h3F_7F02);
    endtask

    task automatic t_alu();
        do_pop('0);
        alu_upd_en = 1; alu_mask = 6'b100001; alu_flags = 6'b111111;
        step();
        chk("R6 carry and overflow", flags_q, 64'h803);
        alu_upd_en = 1; alu_mask = 6'b000010; alu_flags = 6'b000110;
        step();
        chk("R6 parity only", flags_q, 64'h807);
        alu_upd_en = 1; alu_mask = 6'b011100; alu_flags = 6'b011000;
        step();
        chk("R6 zero sign aux", flags_q, 64'h8C7);
        alu_upd_en = 1; alu_mask = 6'b000000; alu_flags = 6'b000000;
        step();
        chk("R6 empty mask", flags_q, 64'h8C7);
    endtask

    task automatic t_dir();
        dir_set = 1;
        step();
        chk("R7 set direction", flags_q, 64'hCC7);
        chk("R9 dir output", {63'h0, dir_o}, 64'h1);
        dir_clear = 1;
        step();
        chk("R7 clear direction", flags_q, 64'h8C7);
        dir_set = 1;
        step();
        dir_set = 1; dir_clear = 1;
        step();
        chk("R7 clear wins", flags_q, 64'h8C7);
    endtask

    task automatic t_prio();
        pop_load_en = 1; pop_data = 64'h1;
        byte_store_en = 1; byte_in = 8'hFF;
        alu_upd_en = 1; alu_mask = '1; alu_flags = '1;
        dir_set = 1;
        step();
        chk("R8 pop wins all", flags_q, 64'h3);
        byte_store_en = 1; byte_in = 8'h00;
        alu_upd_en = 1; alu_mask = '1; alu_flags = '1;
        step();
        chk("R8 byte beats arithmetic", flags_q, 64'h2);
        alu_upd_en = 1; alu_mask = 6'b100000; alu_flags = 6'b100000;
        dir_set = 1;
        step();
        chk("R8 arithmetic beats direction", flags_q, 64'h802);
    endtask

    task automatic t_hold();
        do_pop('1);
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R10 idle hold", flags_q, 64'h3F_7FD7);
        end
    endtask

    task automatic t_reset_mid();
        rst_n = 0;
        step();
        chk("R1 reset mid run", flags_q, 64'h2);
        rst_n = 1;
        step();
        chk("R1 after reset release", flags_q, 64'h2);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_pop();
        t_byte();
        t_alu();
        t_dir();
        t_prio();
        t_hold();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule